// File: doc/BRIEF.md
# TLB Demap Invalidation Engine

This block clears entries of a 64-entry translation buffer whose entries are tagged with a context. It starts when it receives a demap request. Three bits of the request address control the request. One bit picks between two operations: removing one page, or removing everything that belongs to one context. Two bits pick where the context value comes from: the primary context register, the secondary context register, or the fixed nucleus context, which is zero.

Once a request is accepted, the engine walks through every entry in index order, one entry per clock. It reads each entry's tag and attribute bits through a read port that has no latency. Every entry that qualifies gets a one-hot invalidate strobe. After the last entry, the engine gives a single-cycle done pulse. The instruction buffer and the data buffer each get their own copy of this engine.

Top module: `tlb_demap_engine`

## Requirements
- R1: After reset, `busy`, `done` and every bit of `inv_strobe` are 0.
- R2: If `req_valid` is high at a rising edge while the engine is idle, the request is accepted. From the next cycle, `rd_idx` steps through entries 0 to 63, one per cycle. The strobe for entry i appears one cycle after `rd_idx` shows i. `done` is high for exactly one cycle, and that cycle is the one in which the strobe for entry 63 appears.
- R3: While `busy` is high, a new request is ignored: it does not restart or extend the scan, and it does not start another scan afterwards.
- R4: Request address bit 6 picks the operation: 1 means demap by context, 0 means demap by page. Bits 5:4 pick the context: 0 is `prim_ctx`, 1 is `sec_ctx`, 2 is the value zero.
- R5: When bits 5:4 equal 3, the request invalidates no entry, but it still completes with `done`.
- R6: A context demap invalidates every entry with `rd_valid` = 1, `rd_global` = 0, and `rd_tag[12:0]` equal to the selected context. Global entries are never removed by a context demap.
- R7: A page demap compares the request address with `rd_tag` under a mask. The mask clears bits below 13 + 3·`rd_size`, so size 0 compares from bit 13 upward and size 3 compares from bit 22 upward.
- R8: A page demap that matches on address invalidates the entry only if `rd_global` = 1 or `rd_tag[12:0]` equals the selected context.
- R9: An entry with `rd_valid` = 0 is never invalidated.
- R10: The context value is captured when the request is accepted. Changes to `prim_ctx` or `sec_ctx` during the scan have no effect on it.
- R11: In any cycle, at most one bit of `inv_strobe` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Demap request strobe |
| req_addr | input | 64 | Demap address: page address plus control bits 6:4 |
| prim_ctx | input | 13 | Primary context register |
| sec_ctx | input | 13 | Secondary context register |
| rd_idx | output | 6 | Index of the entry being read |
| rd_tag | input | 64 | Tag of entry `rd_idx`: virtual address above bit 12, context in bits 12:0 |
| rd_valid | input | 1 | Valid bit of entry `rd_idx` |
| rd_global | input | 1 | Global bit of entry `rd_idx` |
| rd_size | input | 2 | Page-size code of entry `rd_idx` |
| inv_strobe | output | 64 | One-hot invalidate strobe per entry |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse at the end of a scan |

## Verification
The hardest case to reach is a page demap where the page-size mask decides the result. An entry whose address differs from the request only in bits 13 to 21 must match at a large size and miss at the smallest size. The directed table places neighbouring entries whose addresses differ in exactly those bits, at several sizes. The random tables draw each address from a few shared bases, so such near-misses happen often. Entries are also placed so that they match on address but not on context, or are global, so the global/context rule is exercised on both sides. A disturbing request, sent mid-scan together with changed context registers, checks that the request is ignored and that the context captured at acceptance is kept.

// File: rtl/demap_pkg.sv
package demap_pkg;
  // request control field positions inside the demap address
  localparam int OP_BIT  = 6;
  localparam int CSEL_LO = 4;
  localparam int CTL_W   = OP_BIT - CSEL_LO + 1;

  typedef enum logic [1:0] {
    CSEL_PRIM = 2'd0,
    CSEL_SEC  = 2'd1,
    CSEL_NUC  = 2'd2,
    CSEL_RSV  = 2'd3
  } ctx_sel_e;
endpackage

// File: rtl/demap_req_decode.sv
module demap_req_decode
  import demap_pkg::*;
#(
  parameter int CTX_W = 13
) (
  input  logic [CTL_W-1:0] ctl,
  input  logic [CTX_W-1:0] prim_ctx,
  input  logic [CTX_W-1:0] sec_ctx,
  output logic             by_ctx,
  output logic             reserved,
  output logic [CTX_W-1:0] ctx
);
  ctx_sel_e sel;

  always_comb begin
    sel      = ctx_sel_e'(ctl[1:0]);
    by_ctx   = ctl[CTL_W-1];
    reserved = (sel == CSEL_RSV);
    unique case (sel)
      CSEL_PRIM: ctx = prim_ctx;
      CSEL_SEC:  ctx = sec_ctx;
      default:   ctx = '0;
    endcase
  end
endmodule

// File: rtl/demap_entry_match.sv
module demap_entry_match #(
  parameter int ADDR_W     = 64,
  parameter int CTX_W      = 13,
  parameter int PAGE_SHIFT = 13,
  parameter int SIZE_W     = 2,
  parameter int SIZE_STEP  = 3
) (
  input  logic              by_ctx,
  input  logic              reserved,
  input  logic [CTX_W-1:0]  ctx,
  input  logic [ADDR_W-1:0] va,
  input  logic [ADDR_W-1:0] tag,
  input  logic              ent_valid,
  input  logic              ent_global,
  input  logic [SIZE_W-1:0] ent_size,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] BASE_MASK = {ADDR_W{1'b1}} << PAGE_SHIFT;

  logic [ADDR_W-1:0] mask;
  logic              ctx_eq;
  logic              va_eq;

  always_comb begin
    mask   = BASE_MASK << (SIZE_STEP * int'(ent_size));
    ctx_eq = (tag[CTX_W-1:0] == ctx);
    va_eq  = ((va ^ tag) & mask) == '0;
    if (!ent_valid || reserved)
      hit = 1'b0;
    else if (by_ctx)
      hit = !ent_global && ctx_eq;
    else
      hit = va_eq && (ent_global || ctx_eq);
  end
endmodule

// File: rtl/tlb_demap_engine.sv
module tlb_demap_engine
  import demap_pkg::*;
#(
  parameter int ENTRIES    = 64,
  parameter int ADDR_W     = 64,
  parameter int CTX_W      = 13,
  parameter int PAGE_SHIFT = 13,
  parameter int SIZE_W     = 2,
  parameter int SIZE_STEP  = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [CTX_W-1:0]           prim_ctx,
  input  logic [CTX_W-1:0]           sec_ctx,
  output logic [$clog2(ENTRIES)-1:0] rd_idx,
  input  logic [ADDR_W-1:0]          rd_tag,
  input  logic                       rd_valid,
  input  logic                       rd_global,
  input  logic [SIZE_W-1:0]          rd_size,
  output logic [ENTRIES-1:0]         inv_strobe,
  output logic                       busy,
  output logic                       done
);
  localparam int               IDX_W = $clog2(ENTRIES);
  localparam logic [IDX_W-1:0] LAST  = IDX_W'(ENTRIES - 1);

  logic              dec_by_ctx, dec_rsv;
  logic [CTX_W-1:0]  dec_ctx;

  logic              busy_q, done_q, by_ctx_q, rsv_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CTX_W-1:0]  ctx_q;
  logic [ENTRIES-1:0] inv_q;
  logic              hit;

  demap_req_decode #(.CTX_W(CTX_W)) u_dec (
    .ctl      (req_addr[OP_BIT:CSEL_LO]),
    .prim_ctx (prim_ctx),
    .sec_ctx  (sec_ctx),
    .by_ctx   (dec_by_ctx),
    .reserved (dec_rsv),
    .ctx      (dec_ctx)
  );

  demap_entry_match #(
    .ADDR_W(ADDR_W), .CTX_W(CTX_W), .PAGE_SHIFT(PAGE_SHIFT),
    .SIZE_W(SIZE_W), .SIZE_STEP(SIZE_STEP)
  ) u_match (
    .by_ctx     (by_ctx_q),
    .reserved   (rsv_q),
    .ctx        (ctx_q),
    .va         (addr_q),
    .tag        (rd_tag),
    .ent_valid  (rd_valid),
    .ent_global (rd_global),
    .ent_size   (rd_size),
    .hit        (hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      by_ctx_q <= 1'b0;
      rsv_q    <= 1'b0;
      idx_q    <= '0;
      addr_q   <= '0;
      ctx_q    <= '0;
      inv_q    <= '0;
    end else begin
      done_q <= 1'b0;
      inv_q  <= '0;
      if (!busy_q) begin
        if (req_valid) begin
          busy_q   <= 1'b1;
          idx_q    <= '0;
          addr_q   <= req_addr;
          by_ctx_q <= dec_by_ctx;
          rsv_q    <= dec_rsv;
          ctx_q    <= dec_ctx;
        end
      end else begin
        inv_q[idx_q] <= hit;
        idx_q        <= idx_q + 1'b1;
        if (idx_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign rd_idx     = idx_q;
  assign inv_strobe = inv_q;
  assign busy       = busy_q;
  assign done       = done_q;

  assert_onehot_inv_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(inv_strobe));

  assert_done_after_last_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy_q) && $past(idx_q) == LAST));

  assert_busy_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (busy_q && idx_q != LAST) |=> busy_q);

  assert_ctx_latched_R10: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> $stable(ctx_q));

  assert_rsv_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (busy_q && rsv_q) |=> (inv_strobe == '0));

  assert_global_spared_R6: assert property (@(posedge clk) disable iff (rst)
    (busy_q && by_ctx_q && rd_global) |=> (inv_strobe == '0));

  assert_invalid_skip_R9: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !rd_valid) |=> (inv_strobe == '0));
endmodule

// File: tb/tb_tlb_demap_engine.sv
`timescale 1ns/1ps
module tb_tlb_demap_engine;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [63:0] req_addr;
  logic [12:0] prim_ctx, sec_ctx;
  logic [5:0]  rd_idx;
  logic [63:0] rd_tag;
  logic        rd_valid, rd_global;
  logic [1:0]  rd_size;
  logic [63:0] inv_strobe;
  logic        busy, done;

  logic [63:0] tags  [64];
  logic        vld   [64];
  logic        glb   [64];
  logic [1:0]  sz    [64];

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  assign rd_tag    = tags[rd_idx];
  assign rd_valid  = vld[rd_idx];
  assign rd_global = glb[rd_idx];
  assign rd_size   = sz[rd_idx];

  tlb_demap_engine dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .prim_ctx(prim_ctx), .sec_ctx(sec_ctx), .rd_idx(rd_idx),
    .rd_tag(rd_tag), .rd_valid(rd_valid), .rd_global(rd_global),
    .rd_size(rd_size), .inv_strobe(inv_strobe), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] expect_mask(input logic [63:0] a,
                                              input logic [12:0] p,
                                              input logic [12:0] s);
    logic [63:0] r = '0;
    logic [12:0] c;
    logic [63:0] m;
    if (a[5:4] == 2'd3) return '0;
    c = (a[5:4] == 2'd0) ? p : (a[5:4] == 2'd1) ? s : 13'd0;
    for (int i = 0; i < 64; i++) begin
      if (!vld[i]) continue;
      if (a[6]) begin
        if (!glb[i] && tags[i][12:0] == c) r[i] = 1'b1;
      end else begin
        m = 64'hFFFF_FFFF_FFFF_E000 << (3 * sz[i]);
        if (((a ^ tags[i]) & m) == '0 && (glb[i] || tags[i][12:0] == c))
          r[i] = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic string mode_req(input logic [63:0] a);
    if (a[5:4] == 2'd3) return "R5";
    if (a[6]) return "R6";
    return "R7 R8";
  endfunction

  task automatic demap(input logic [63:0] a, input logic [12:0] p,
                       input logic [12:0] s, input bit disturb,
                       output logic [63:0] got);
    logic [63:0] exp;
    bit idx_ok = 1'b1;
    bit oh_ok  = 1'b1;
    int done_at = -1;
    int done_cnt = 0;
    @(negedge clk);
    prim_ctx = p; sec_ctx = s; req_addr = a; req_valid = 1'b1;
    exp = expect_mask(a, p, s);
    @(negedge clk);
    req_valid = 1'b0;
    got = '0;
    for (int j = 0; j < 67; j++) begin
      if (j < 64 && (rd_idx != j[5:0] || !busy)) idx_ok = 1'b0;
      if (done) begin
        done_cnt++;
        if (done_at < 0) done_at = j;
      end
      if ($countones(inv_strobe) > 1) oh_ok = 1'b0;
      got |= inv_strobe;
      if (disturb && j == 10) begin
        req_valid = 1'b1;
        req_addr  = a ^ 64'h70;
        prim_ctx  = ~p;
        sec_ctx   = ~s;
      end
      if (disturb && j == 11) req_valid = 1'b0;
      @(negedge clk);
    end
    check(done_at == 64 && done_cnt == 1, "R2", "done cycle",
          64'(done_at), 64'd64);
    check(idx_ok, "R2", "scan order", {63'd0, idx_ok}, 64'd1);
    check(oh_ok, "R11", "one-hot strobe", {63'd0, oh_ok}, 64'd1);
    check(got == exp, disturb ? "R10" : mode_req(a), "invalidated set", got, exp);
    check(!busy, "R3", "idle after scan", {63'd0, busy}, 64'd0);
  endtask

  task automatic clear_table();
    for (int i = 0; i < 64; i++) begin
      tags[i] = '0; vld[i] = 1'b0; glb[i] = 1'b0; sz[i] = 2'd0;
    end
  endtask

  task automatic put(input int i, input logic [63:0] va, input logic [12:0] c,
                     input bit v, input bit g, input logic [1:0] s);
    tags[i] = {va[63:13], c}; vld[i] = v; glb[i] = g; sz[i] = s;
  endtask

  localparam logic [63:0] B = 64'h0000_0040_0000_0000;

  initial begin
    logic [63:0] got;
    logic [63:0] bases [4];
    logic [12:0] p, s, c;
    logic [63:0] a;
    void'($urandom(32'd20240517));
    req_valid = 1'b0; req_addr = '0; prim_ctx = '0; sec_ctx = '0;
    clear_table();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && inv_strobe == '0, "R1", "reset state",
          {busy, done, 62'd0} | inv_strobe, 64'd0);

    // directed table
    put(0, B,             13'h005, 1, 0, 2'd0);
    put(1, B,             13'h005, 0, 0, 2'd0);
    put(2, B,             13'h003, 1, 1, 2'd0);
    put(3, B + 64'h2000,  13'h005, 1, 0, 2'd0);
    put(4, B + 64'h2000,  13'h005, 1, 0, 2'd1);
    put(5, B,             13'h0A0, 1, 0, 2'd0);
    put(6, B + 64'h10_0000, 13'h000, 1, 0, 2'd3);
    put(7, B,             13'h000, 1, 0, 2'd0);

    demap(B | 64'h00, 13'h005, 13'h0A0, 0, got);       // page, primary
    check(got[0], "R8", "ctx-matching page entry removed", got, 64'h15);
    check(!got[1], "R9", "invalid entry skipped", got, 64'h15);
    check(got[2], "R8", "global page entry removed", got, 64'h15);
    check(!got[3], "R7", "size0 bit13 miss", got, 64'h15);
    check(got[4], "R7", "size1 wider mask hit", got, 64'h15);
    check(!got[5], "R8", "other ctx spared", got, 64'h15);

    demap(B | 64'h50, 13'h005, 13'h0A0, 0, got);       // ctx, secondary
    check(got == 64'h20, "R4", "secondary context select", got, 64'h20);
    check(!got[2], "R6", "global spared by ctx demap", got, 64'h20);

    demap(B | 64'h40, 13'h005, 13'h0A0, 0, got);       // ctx, primary
    check(got == 64'h19, "R6", "primary context demap", got, 64'h19);

    demap(B | 64'h20, 13'h005, 13'h0A0, 0, got);       // page, nucleus
    check(got == 64'hC4, "R4", "nucleus page demap", got, 64'hC4);

    demap(B | 64'h30, 13'h005, 13'h0A0, 0, got);       // reserved page
    check(got == '0, "R5", "reserved page select", got, 64'h0);
    demap(B | 64'h70, 13'h005, 13'h0A0, 0, got);       // reserved ctx
    check(got == '0, "R5", "reserved ctx select", got, 64'h0);

    demap(B | 64'h40, 13'h005, 13'h0A0, 1, got);       // disturbed scan
    check(got == 64'h19, "R3", "mid-scan request ignored", got, 64'h19);

    // random tables
    bases[0] = B; bases[1] = B + 64'h2000;
    bases[2] = B + 64'h1_0000; bases[3] = 64'h0000_7FFF_FFC0_0000;
    for (int r = 0; r < 24; r++) begin
      p = 13'($urandom_range(1, 8191));
      s = 13'($urandom_range(1, 8191));
      for (int i = 0; i < 64; i++) begin
        case ($urandom_range(0, 3))
          0: c = p;
          1: c = s;
          2: c = 13'd0;
          default: c = 13'($urandom);
        endcase
        put(i, bases[$urandom_range(0, 3)] ^ (64'($urandom_range(0, 7)) << 13),
            c, $urandom_range(0, 9) < 8, $urandom_range(0, 4) == 0,
            2'($urandom_range(0, 3)));
      end
      a = bases[$urandom_range(0, 3)] | (64'($urandom_range(0, 7)) << 4)
          | (64'($urandom_range(0, 63)) << 7);
      demap(a, p, s, r % 6 == 5, got);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule